// File: doc/BRIEF.md
# Low-speed USB packet serialiser

This block drives a packet onto the D+ and D- lines of a low-speed USB link. When `start` is pulsed while the block is idle, it does three things in order. It first presets the lines to the idle J state. One cycle later it turns on the output drivers. It then sends a sync byte of 0x80, followed by the payload bytes pulled from a simple byte source. Every byte goes out least significant bit first. The bits are NRZI coded and bit stuffed through a single encoder.

When the bytes are used up, the block sends an end-of-packet sequence of two SE0 bit times and one J bit time. It then turns the drivers off with both lines low and emits a one-cycle `done` pulse. That pulse can be used to commit a deferred device address. Bit timing comes from a clock-enable divider of `BIT_DIV` system clocks per bit. With a suitable system clock this keeps the bit rate within 1.5% of 1.5 Mb/s. CRC generation and the choice of packet are left to the logic that feeds the source.

Top module: `ls_pkt_tx`

## Requirements
- R1: After reset and between packets, `oe`, `dp`, `dm`, `busy` and `done` are all 0.
- R2: In the cycle after `start` is taken, the lines are J (`dp`=0, `dm`=1) with `oe` still 0. `oe` rises one cycle later and holds J for one bit time before the first bit appears.
- R3: The first byte on the line is 0x80, sent LSb first, so that seven K/J alternations end in a doubled K.
- R4: NRZI coding is used. A 0 bit toggles the line and a 1 bit holds it. J is {`dp`,`dm`}={0,1}, K is {1,0}, and {1,1} never appears while `oe` is high.
- R5: After six consecutive 1 bits, the line toggles once as a stuffed bit and the run count restarts. The run count is zero at the start of sync. A stuff that falls due after the last data bit is still sent before the end of packet.
- R6: The total byte count including sync is `pkt_len` limited to the range 2..`MAX_BYTES`. Values below 2 act as 2 and values above `MAX_BYTES` act as `MAX_BYTES`, so at most count-1 payload bytes are taken.
- R7: A byte is taken from the source one bit time before the current byte ends, marked by a one-cycle `src_pop`. If `src_valid` is low at that moment, the packet ends after the current byte.
- R8: The end of packet is SE0 for two bit times, then J for one bit time. After that `oe` falls and both lines are left at 0.
- R9: Every line symbol, including the leading J and the end-of-packet symbols, lasts exactly `BIT_DIV` clock cycles.
- R10: `busy` is high from the cycle after `start` is taken until `oe` falls. `done` is a single-cycle pulse in the first cycle with `oe` low.
- R11: `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a packet (taken only while idle) |
| pkt_len | input | LEN_W | Total byte count including sync |
| src_valid | input | 1 | Byte source has a byte on `src_data` |
| src_data | input | 8 | Next payload byte |
| src_pop | output | 1 | One-cycle pulse: the offered byte was taken |
| busy | output | 1 | Packet in progress |
| dp | output | 1 | D+ line level |
| dm | output | 1 | D- line level |
| oe | output | 1 | Line driver enable |
| done | output | 1 | One-cycle pulse after the drivers are released |

## Verification
The J preset is visible one cycle after `start` is taken, and `oe` rises one cycle after that. From the rise of `oe`, line symbol k occupies cycles k·`BIT_DIV` to k·`BIT_DIV`+`BIT_DIV`-1. The bench therefore samples each symbol half a bit into that window, on the falling clock edge. `oe` must then stay high for exactly (symbols)·`BIT_DIV` cycles. `done` is expected in the first falling-edge sample with `oe` low and must be gone in the next. The expected symbol streams, stuff positions and byte counts are computed in the bench from the requirement text, for every one-byte payload value and for a set of multi-byte, clamped and underflowing packets.

// File: rtl/lstx_pkg.sv
package lstx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_DATA,
    ST_EOP0,
    ST_EOP1,
    ST_EOPJ
  } tx_state_t;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam int STUFF_RUN = 6;
  localparam int MIN_BYTES = 2;

endpackage

// File: rtl/lstx_bit_timer.sv
module lstx_bit_timer #(
  parameter int BIT_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lstx_nrzi_stuff.sv
module lstx_nrzi_stuff #(
  parameter int RUN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic adv,
  input  logic bit_in,
  output logic lvl_d,
  output logic stuff_due
);
  localparam int OW = $clog2(RUN + 1);

  logic          lvl_q;   // 0 = J, 1 = K
  logic [OW-1:0] ones_q, ones_d;

  assign stuff_due = (ones_q == OW'(RUN));

  always_comb begin
    lvl_d  = lvl_q;
    ones_d = ones_q;
    if (adv) begin
      if (stuff_due || !bit_in) begin
        lvl_d  = ~lvl_q;
        ones_d = '0;
      end else begin
        ones_d = ones_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      lvl_q  <= 1'b0;
      ones_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      ones_q <= ones_d;
    end
  end
endmodule

// File: rtl/lstx_byte_feed.sv
module lstx_byte_feed #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [7:0]       first_byte,
  input  logic [CNT_W-1:0] payload_n,
  input  logic             consume,
  input  logic             src_valid,
  input  logic [7:0]       src_data,
  output logic             cur_bit,
  output logic             drained,
  output logic             src_pop
);
  logic [7:0]       shreg;
  logic [2:0]       idx;
  logic [CNT_W-1:0] left;
  logic [7:0]       nxt;
  logic             have;

  assign cur_bit = shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      idx     <= '0;
      left    <= '0;
      nxt     <= '0;
      have    <= 1'b0;
      drained <= 1'b1;
      src_pop <= 1'b0;
    end else begin
      src_pop <= 1'b0;
      if (load) begin
        shreg   <= first_byte;
        idx     <= '0;
        left    <= payload_n;
        have    <= 1'b0;
        drained <= 1'b0;
      end else if (consume) begin
        if (idx == 3'd6 && left != '0) begin
          nxt     <= src_data;
          have    <= src_valid;
          src_pop <= src_valid;
        end
        if (idx == 3'd7) begin
          if (left != '0 && have) begin
            shreg <= nxt;
            left  <= left - 1'b1;
            have  <= 1'b0;
            idx   <= '0;
          end else begin
            drained <= 1'b1;
          end
        end else begin
          shreg <= {1'b0, shreg[7:1]};
          idx   <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ls_pkt_tx.sv
module ls_pkt_tx #(
  parameter int BIT_DIV   = 8,
  parameter int MAX_BYTES = 12,
  parameter int LEN_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             src_valid,
  input  logic [7:0]       src_data,
  output logic             src_pop,
  output logic             busy,
  output logic             dp,
  output logic             dm,
  output logic             oe,
  output logic             done
);
  import lstx_pkg::*;

  tx_state_t        st;
  logic             tick, stuff_due, lvl_d, cur_bit, drained;
  logic             enc_adv, consume, load;
  logic [LEN_W-1:0] len_eff;

  always_comb begin
    if (pkt_len < LEN_W'(MIN_BYTES))      len_eff = LEN_W'(MIN_BYTES);
    else if (pkt_len > LEN_W'(MAX_BYTES)) len_eff = LEN_W'(MAX_BYTES);
    else                                  len_eff = pkt_len;
  end

  assign load    = (st == ST_IDLE) && start;
  assign enc_adv = (st == ST_DATA) && tick && (stuff_due || !drained);
  assign consume = (st == ST_DATA) && tick && !stuff_due && !drained;

  lstx_bit_timer #(.BIT_DIV(BIT_DIV)) u_timer (
    .clk(clk), .rst(rst),
    .restart((st == ST_IDLE) || (st == ST_ARM)),
    .tick(tick)
  );

  lstx_nrzi_stuff #(.RUN(STUFF_RUN)) u_enc (
    .clk(clk), .rst(rst), .clear(st == ST_IDLE),
    .adv(enc_adv), .bit_in(cur_bit),
    .lvl_d(lvl_d), .stuff_due(stuff_due)
  );

  lstx_byte_feed #(.CNT_W(LEN_W)) u_feed (
    .clk(clk), .rst(rst), .load(load),
    .first_byte(SYNC_BYTE), .payload_n(len_eff - 1'b1),
    .consume(consume), .src_valid(src_valid), .src_data(src_data),
    .cur_bit(cur_bit), .drained(drained), .src_pop(src_pop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      dp   <= 1'b0;
      dm   <= 1'b0;
      oe   <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          dp   <= 1'b0;
          dm   <= 1'b1;
          busy <= 1'b1;
          st   <= ST_ARM;
        end
        ST_ARM: begin
          oe <= 1'b1;
          st <= ST_DATA;
        end
        ST_DATA: if (tick) begin
          if (enc_adv) begin
            dp <= lvl_d;
            dm <= ~lvl_d;
          end else begin
            dp <= 1'b0;
            dm <= 1'b0;
            st <= ST_EOP0;
          end
        end
        ST_EOP0: if (tick) st <= ST_EOP1;
        ST_EOP1: if (tick) begin
          dm <= 1'b1;
          st <= ST_EOPJ;
        end
        ST_EOPJ: if (tick) begin
          oe   <= 1'b0;
          dp   <= 1'b0;
          dm   <= 1'b0;
          busy <= 1'b0;
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ls_pkt_tx_chk.sv
module ls_pkt_tx_chk #(
  parameter int BIT_DIV = 8
) (
  input logic clk,
  input logic rst,
  input logic dp,
  input logic dm,
  input logic oe,
  input logic busy,
  input logic done,
  input logic src_pop
);
  localparam int PW = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst || !oe)                 ph <= '0;
    else if (ph == PW'(BIT_DIV - 1)) ph <= '0;
    else                            ph <= ph + 1'b1;
  end

  // R2
  j_before_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> ($past(dm) && !$past(dp)));

  // R4
  no_se1_chk: assert property (@(posedge clk) disable iff (rst)
    oe |-> !(dp && dm));

  // R9
  bit_grid_chk: assert property (@(posedge clk) disable iff (rst)
    (oe && $past(oe) && ({dp, dm} != $past({dp, dm}))) |-> (ph == '0));

  // R8
  release_low_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!oe && !dp && !dm));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R7
  pop_in_packet_chk: assert property (@(posedge clk) disable iff (rst)
    src_pop |-> (busy && oe));
endmodule

bind ls_pkt_tx ls_pkt_tx_chk #(.BIT_DIV(BIT_DIV)) u_chk (
  .clk(clk), .rst(rst), .dp(dp), .dm(dm), .oe(oe),
  .busy(busy), .done(done), .src_pop(src_pop)
);

// File: tb/ls_pkt_tx_tb.sv
`timescale 1ns/1ps
module ls_pkt_tx_tb;
  localparam int DIV  = 4;
  localparam int MAXB = 12;
  localparam logic [1:0] SJ = 2'b01, SK = 2'b10, SE0 = 2'b00;

  logic       clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [3:0] pkt_len = '0;
  logic [7:0] pl [0:15];
  int         avail = 0;
  logic [4:0] src_idx;
  logic       src_valid;
  logic [7:0] src_data;
  logic       src_pop, busy, dp, dm, oe, done;

  int nchk = 0, nerr = 0;
  logic [1:0] exp_sym [0:255];
  logic [1:0] got_sym [0:255];

  always #2.5 clk = ~clk;

  assign src_valid = (int'(src_idx) < avail);
  assign src_data  = pl[src_idx[3:0]];

  always @(posedge clk) begin
    if (rst || start) src_idx <= '0;
    else if (src_pop) src_idx <= src_idx + 1'b1;
  end

  ls_pkt_tx #(.BIT_DIV(DIV), .MAX_BYTES(MAXB), .LEN_W(4)) u_dut (
    .clk(clk), .rst(rst), .start(start), .pkt_len(pkt_len),
    .src_valid(src_valid), .src_data(src_data), .src_pop(src_pop),
    .busy(busy), .dp(dp), .dm(dm), .oe(oe), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic run_pkt(input int len_req, input int av, input bit poke);
    int n, nb, s, lvl, ones, t, bad, first_bad;
    logic [7:0] v;
    n  = (len_req < 2) ? 2 : ((len_req > MAXB) ? MAXB : len_req);
    nb = 1 + (((n - 1) < av) ? (n - 1) : av);
    avail = av;
    s = 0; lvl = 0; ones = 0;
    exp_sym[s++] = SJ;
    for (int b = 0; b < nb; b++) begin
      v = (b == 0) ? 8'h80 : pl[b-1];
      for (int i = 0; i < 8; i++) begin
        if (!v[i]) begin lvl ^= 1; ones = 0; end
        else ones++;
        exp_sym[s++] = lvl ? SK : SJ;
        if (ones == 6) begin
          lvl ^= 1; ones = 0;
          exp_sym[s++] = lvl ? SK : SJ;
        end
      end
    end
    exp_sym[s++] = SE0; exp_sym[s++] = SE0; exp_sym[s++] = SJ;

    @(negedge clk); pkt_len = 4'(len_req); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    chk(oe == 1'b0 && {dp, dm} == SJ, "R2", "J preset before enable",
        {oe, dp, dm}, {1'b0, SJ});
    @(negedge clk);
    chk(oe == 1'b1, "R2", "oe one cycle after preset", oe, 1);
    t = 0;
    while (oe && t < 4000) begin
      if (t % DIV == DIV / 2) got_sym[t / DIV] = {dp, dm};
      start = (poke && t == 3 * DIV) ? 1'b1 : 1'b0;
      t++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(t == s * DIV, "R9", "oe high cycles", t, s * DIV);
    chk(done && !busy && !dp && !dm, "R8", "done pulse and lines released",
        {done, busy, dp, dm}, 4'b1000);
    bad = 0; first_bad = -1;
    for (int k = 0; k < s; k++)
      if (got_sym[k] !== exp_sym[k]) begin
        bad++;
        if (first_bad < 0) first_bad = k;
      end
    if (bad != 0)
      chk(1'b0, "R3,R4,R5", $sformatf("symbol %0d", first_bad),
          got_sym[first_bad], exp_sym[first_bad]);
    else
      chk(1'b1, "R3,R4,R5", "symbol stream", 0, 0);
    chk(int'(src_idx) == nb - 1, "R6,R7", "bytes taken", src_idx, nb - 1);
    @(negedge clk);
    chk(!done && !oe && !busy, "R10", "done single cycle", {done, oe, busy}, 0);
    if (poke) begin
      repeat (3 * DIV) @(negedge clk);
      chk(!oe && !busy, "R11", "start while busy ignored", {oe, busy}, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [15:0] seed;
    for (int i = 0; i < 16; i++) pl[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 idle state after reset
    chk(!oe && !dp && !dm && !busy && !done, "R1", "reset idle",
        {oe, dp, dm, busy, done}, 0);
    // R5: run of ones in payload, then a stuff after the last data bit
    pl[0] = 8'hFF; run_pkt(2, 1, 1'b0);
    pl[0] = 8'hFC; run_pkt(2, 1, 1'b0);
    pl[0] = 8'h3F; pl[1] = 8'h00; run_pkt(3, 2, 1'b0);
    // R6 clamping below and above
    run_pkt(1, 5, 1'b0);
    for (int i = 0; i < 15; i++) pl[i] = 8'(i * 37 + 5);
    run_pkt(15, 15, 1'b0);
    // R7 source underflow
    run_pkt(6, 2, 1'b0);
    run_pkt(4, 0, 1'b0);
    // R11 start mid-packet
    run_pkt(3, 2, 1'b1);
    // R1 idle between packets
    chk(!oe && !dp && !dm && !busy, "R1", "idle after packets",
        {oe, dp, dm, busy}, 0);
    // R3,R4,R5 sweep of every single payload byte value
    for (int v = 0; v < 256; v++) begin
      pl[0] = 8'(v);
      run_pkt(2, 1, 1'b0);
    end
    // multi-byte packets of every length
    seed = 16'hACE1;
    for (int p = 0; p < 33; p++) begin
      for (int i = 0; i < 12; i++) begin
        seed = seed * 16'd25173 + 16'd13849;
        pl[i] = (p % 3 == 0) ? 8'hFF : seed[15:8];
      end
      run_pkt(2 + (p % 11), 12, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule